// File: doc/BRIEF.md
# Gated Event Counter with Strobe-Clocked Readback

This block is a 12-bit event counter for a frequency and time-interval instrument. Counting runs on one system clock. The thing being counted is chosen by a static 2-bit source mode:

- rising edges of the measured input, for frequency measurement;
- rising edges of the reference-clock input, for interval measurement;
- rising edges of a read strobe driven by a controller, for readback.

A gate input opens and closes the counting window. The gate and every event input pass through a synchronizer. Events are turned into single-cycle enables by rising-edge detection, so no clock is ever ANDed with a gate. The number of extra counts therefore does not depend on the duty cycle of the counted signal, and an asynchronous gate cannot break a register's timing.

The counter's most significant bit is driven out as a carry line. An outside agent can count its transitions and extend the range, for example to 12+24 bits. A one-cycle wrap pulse marks each roll-over from 4095 to 0.

The counter has no parallel read port. To read it, the controller selects the strobe source and sends strobes until the wrap pulse appears. The held value is 4096 minus the number of strobes sent, where 4096 strobes means the value 0. This readback is destructive: the counter is left at zero.

A small controller state machine sequences each measurement:

- **IDLE**: waiting for the gate to open.
- **COUNT**: the gate is open and events are counted.
- **DONE**: the value is frozen until it is cleared.
- **READ**: strobe-clocked readback.

Its transitions are:

- IDLE→COUNT when the synchronized gate is high in a counting mode.
- COUNT→DONE when the synchronized gate falls.
- IDLE/COUNT/DONE→READ when the strobe mode is selected.
- READ→DONE when any other mode is selected.
- COUNT/DONE→IDLE on a synchronous clear.

In IDLE, counting already starts in the cycle the synchronized gate is first seen high.

Top module: `evcnt_top`

## Requirements
- R1: After reset the count is zero, `carry_o` and `wrap_o` are low, and the controller is in IDLE.
- R2: With `mode_i` = 2'b00, each rising edge of `sig_i` seen while the gate is open adds one to the count, and edges on `ref_i` and `strobe_i` add nothing.
- R3: With `mode_i` = 2'b01, each rising edge of `ref_i` seen while the gate is open adds one, and edges on `sig_i` add nothing.
- R4: The gate and the event inputs are synchronized. Every rising edge adds exactly one count whatever its high and low widths (down to one clock each). Edges that arrive while the synchronized gate is low are not counted.
- R5: `carry_o` equals bit 11 of the count and changes only when the count changes. `wrap_o` is a one-cycle pulse, three clock edges after the strobe or event rises, each time the count rolls from 4095 to 0.
- R6: With `mode_i` = 2'b10 the controller enters READ. In READ only rising edges of `strobe_i` are counted and `gate_i` has no effect. The number of strobes up to and including the one that raises `wrap_o` equals 4096 minus the held value (4096 for a held zero).
- R7: A high `clr_i` sets the count to zero in the next cycle, takes precedence over any event, and returns COUNT or DONE to IDLE.
- R8: Once the gate has closed after a window (DONE), reopening it without a clear adds nothing to the held value.
- R9: With `mode_i` = 2'b11 no input is counted, whatever the gate does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of the count |
| mode_i | input | 2 | Source mode: 00 input, 01 reference, 10 readback, 11 off |
| gate_i | input | 1 | Asynchronous gate; high opens the counting window |
| sig_i | input | 1 | Measured input, asynchronous |
| ref_i | input | 1 | Reference-clock input, asynchronous |
| strobe_i | input | 1 | Readback strobe from the controller, asynchronous |
| carry_o | output | 1 | Count bit 11, used for range extension |
| wrap_o | output | 1 | One-cycle pulse on roll-over from 4095 to 0 |

## Verification
A wrong controller state or a wrong count shows up at the ports only through `carry_o`, `wrap_o` and the readback strobe count. A miscounted window therefore appears as a wrong value at the end of the next readback, at most 4096 strobes later.

A stuck or mis-sequenced controller shows up sooner in two ways. A window that should be frozen will take extra counts. A readback will need the wrong number of strobes.

A carry that does not track the count becomes visible within the three clock edges of event latency. The bench therefore places its carry and wrap checks right at the 2047/2048 and 4095/0 boundaries.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    typedef enum logic [1:0] {
        SRC_INPUT  = 2'b00,
        SRC_REFCLK = 2'b01,
        SRC_STROBE = 2'b10,
        SRC_OFF    = 2'b11
    } src_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_COUNT = 2'b01,
        ST_DONE  = 2'b10,
        ST_READ  = 2'b11
    } ctl_state_e;

    localparam int unsigned EV_SIG = 0;
    localparam int unsigned EV_REF = 1;
    localparam int unsigned EV_STB = 2;
    localparam int unsigned EV_NUM = 3;

endpackage

// File: rtl/evcnt_sync.sv
module evcnt_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[LAST];
endmodule

// File: rtl/evcnt_edge.sv
module evcnt_edge #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign rise[b] = lvl[b] & ~prev_q[b];
    end
endmodule

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
    import evcnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  src_mode_e  mode,
    input  logic       gate_s,
    input  logic       ev_sig,
    input  logic       ev_ref,
    input  logic       ev_stb,
    output logic       inc,
    output ctl_state_e state
);
    ctl_state_e state_q, state_d;
    logic       src_live;
    logic       sel_ev;

    assign src_live = (mode == SRC_INPUT) || (mode == SRC_REFCLK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mode == SRC_STROBE)             state_d = ST_READ;
                else if (!clr && gate_s && src_live) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (mode == SRC_STROBE) state_d = ST_READ;
                else if (clr)           state_d = ST_IDLE;
                else if (!gate_s)       state_d = ST_DONE;
            end
            ST_DONE: begin
                if (mode == SRC_STROBE) state_d = ST_READ;
                else if (clr)           state_d = ST_IDLE;
            end
            ST_READ: begin
                if (mode != SRC_STROBE) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs: pick the event source for this mode and qualify it by state
    always_comb begin
        unique case (mode)
            SRC_INPUT:  sel_ev = ev_sig;
            SRC_REFCLK: sel_ev = ev_ref;
            default:    sel_ev = 1'b0;
        endcase
        inc = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_COUNT: inc = gate_s & sel_ev;
            ST_READ:           inc = ev_stb;
            ST_DONE:           inc = 1'b0;
            default:           inc = 1'b0;
        endcase
        if (clr) inc = 1'b0;
    end

    assign state = state_q;
endmodule

// File: rtl/evcnt_core.sv
module evcnt_core #(
    parameter int unsigned W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic carry,
    output logic wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         wrap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= !clr && inc && (cnt_q == TOP);
            if (clr)      cnt_q <= '0;
            else if (inc) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign carry = cnt_q[W-1];
    assign wrap  = wrap_q;
endmodule

// File: rtl/evcnt_top.sv
module evcnt_top
    import evcnt_pkg::*;
#(
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic [1:0] mode_i,
    input  logic       gate_i,
    input  logic       sig_i,
    input  logic       ref_i,
    input  logic       strobe_i,
    output logic       carry_o,
    output logic       wrap_o
);
    localparam int unsigned SYNC_W = EV_NUM + 1;
    localparam int unsigned GATE_B = EV_NUM;

    logic [SYNC_W-1:0] raw_w, syn_w;
    logic [EV_NUM-1:0] rise_w;
    logic              gate_s_w;
    logic              ev_sig_w, ev_ref_w, ev_stb_w;
    logic              inc_w;
    ctl_state_e        state_w;
    src_mode_e         mode_w;

    assign mode_w         = src_mode_e'(mode_i);
    assign raw_w[EV_SIG]  = sig_i;
    assign raw_w[EV_REF]  = ref_i;
    assign raw_w[EV_STB]  = strobe_i;
    assign raw_w[GATE_B]  = gate_i;

    evcnt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_w),
        .q     (syn_w)
    );

    evcnt_edge #(.W(EV_NUM)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (syn_w[EV_NUM-1:0]),
        .rise  (rise_w)
    );

    assign gate_s_w = syn_w[GATE_B];
    assign ev_sig_w = rise_w[EV_SIG];
    assign ev_ref_w = rise_w[EV_REF];
    assign ev_stb_w = rise_w[EV_STB];

    evcnt_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_i),
        .mode   (mode_w),
        .gate_s (gate_s_w),
        .ev_sig (ev_sig_w),
        .ev_ref (ev_ref_w),
        .ev_stb (ev_stb_w),
        .inc    (inc_w),
        .state  (state_w)
    );

    evcnt_core #(.W(CNT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_i),
        .inc   (inc_w),
        .carry (carry_o),
        .wrap  (wrap_o)
    );
endmodule

// File: rtl/evcnt_checker.sv
module evcnt_checker
    import evcnt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       clr_i,
    input logic [1:0] mode_i,
    input logic       carry_o,
    input logic       wrap_o,
    input logic       inc,
    input ctl_state_e state,
    input logic       ev_stb
);
    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!carry_o && !wrap_o));

    a_r5_wrap_from_top: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (!carry_o && $past(carry_o)));

    a_r5_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);

    a_r5_carry_moves_on_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr_i) |=> $stable(carry_o));

    a_r8_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> !inc);

    a_r9_off_counts_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SRC_OFF && state != ST_READ) |-> !inc);

    a_r6_read_only_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !ev_stb) |-> !inc);
endmodule

bind evcnt_top evcnt_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .mode_i  (mode_i),
    .carry_o (carry_o),
    .wrap_o  (wrap_o),
    .inc     (inc_w),
    .state   (state_w),
    .ev_stb  (ev_stb_w)
);

// File: tb/evcnt_top_bench.sv
module evcnt_top_bench;
    import evcnt_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n, clr_i, gate_i, sig_i, ref_i, strobe_i;
    logic [1:0] mode_i;
    logic       carry_o, wrap_o;

    int  checks   = 0;
    int  failures = 0;
    int  wrap_cnt = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    evcnt_top u_evcnt_top (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .mode_i(mode_i),
        .gate_i(gate_i), .sig_i(sig_i), .ref_i(ref_i), .strobe_i(strobe_i),
        .carry_o(carry_o), .wrap_o(wrap_o)
    );

    always @(negedge clk) if (rst_n && wrap_o) wrap_cnt++;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_held(int events);
        return events % 4096;
    endfunction

    function automatic int exp_carry(int events);
        return ((events % 4096) >= 2048) ? 1 : 0;
    endfunction

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // which: 0 = sig, 1 = ref, 2 = strobe; called and left at a negedge
    task automatic pulse(int which, int hi, int lo);
        case (which)
            0:       sig_i = 1'b1;
            1:       ref_i = 1'b1;
            default: strobe_i = 1'b1;
        endcase
        repeat (hi) @(negedge clk);
        sig_i = 1'b0; ref_i = 1'b0; strobe_i = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic do_clear();
        clr_i = 1'b1;
        idle(1);
        clr_i = 1'b0;
        idle(1);
    endtask

    // strobe until the wrap pulse; value = 4096 - strobes (R6)
    task automatic read_back(output int val, input bit wiggle_gate);
        int n = 0;
        bit got = 1'b0;
        mode_i = SRC_STROBE;
        idle(3);
        while (!got && n < 4200) begin
            if (wiggle_gate) gate_i = 1'($urandom_range(0, 1));
            pulse(2, 1, 2);
            n++;
            if (wrap_o) got = 1'b1;
        end
        gate_i = 1'b0;
        mode_i = SRC_INPUT;
        idle(3);
        val = got ? (4096 - n) % 4096 : -1;
    endtask

    task automatic measure(logic [1:0] m, int n, bit fast, bit wiggle, output int val);
        int main_src  = (m == SRC_REFCLK) ? 1 : 0;
        int other_src = 1 - main_src;
        do_clear();
        mode_i = m;
        idle(2);
        gate_i = 1'b1;
        idle(4);
        for (int i = 0; i < n; i++) begin
            if (fast) pulse(main_src, 1, 1);
            else begin
                pulse(main_src, $urandom_range(1, 2), $urandom_range(1, 2));
                if ($urandom_range(0, 3) == 0) pulse(other_src, 1, 1);
            end
        end
        idle(4);
        gate_i = 1'b0;
        idle(4);
        read_back(val, wiggle);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog (R1..all) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, n, w0;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; clr_i = 1'b0; gate_i = 1'b0; sig_i = 1'b0;
        ref_i = 1'b0; strobe_i = 1'b0; mode_i = SRC_INPUT;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state at the ports and by readback
        check("R1 carry after reset", int'(carry_o), 0);
        check("R1 wrap after reset", int'(wrap_o), 0);
        read_back(v, 1'b0);
        check("R1 count after reset", v, 0);

        // R2 / R4: input mode, random widths, reference pulses mixed in
        for (int r = 0; r < 3; r++) begin
            n = $urandom_range(3800, 4095);
            measure(SRC_INPUT, n, 1'b0, 1'b0, v);
            check("R2 input-mode count", v, exp_held(n));
        end

        // R3: reference mode, input pulses mixed in
        for (int r = 0; r < 2; r++) begin
            n = $urandom_range(3800, 4095);
            measure(SRC_REFCLK, n, 1'b0, 1'b0, v);
            check("R3 reference-mode count", v, exp_held(n));
        end

        // R4 / R8: edges outside the window and after it closed
        do_clear();
        mode_i = SRC_INPUT;
        for (int i = 0; i < 5; i++) pulse(0, 1, 1);
        idle(2);
        gate_i = 1'b1; idle(4);
        for (int i = 0; i < 7; i++) pulse(0, 2, 1);
        idle(4); gate_i = 1'b0; idle(4);
        for (int i = 0; i < 5; i++) pulse(0, 1, 1);
        gate_i = 1'b1; idle(4);
        for (int i = 0; i < 4; i++) pulse(0, 1, 1);
        idle(4); gate_i = 1'b0; idle(4);
        read_back(v, 1'b0);
        check("R4 R8 only in-window edges held", v, 7);

        // R5: carry at bit 11 and wrap at roll-over
        do_clear();
        mode_i = SRC_INPUT;
        idle(2);
        gate_i = 1'b1; idle(4);
        for (int i = 0; i < 2047; i++) pulse(0, 1, 1);
        idle(4);
        check("R5 carry at 2047", int'(carry_o), exp_carry(2047));
        pulse(0, 1, 1); idle(4);
        check("R5 carry at 2048", int'(carry_o), exp_carry(2048));
        w0 = wrap_cnt;
        for (int i = 0; i < 2048; i++) pulse(0, 1, 1);
        idle(4);
        check("R5 single wrap at 4096", wrap_cnt - w0, 1);
        check("R5 carry after wrap", int'(carry_o), exp_carry(4096));
        for (int i = 0; i < 5; i++) pulse(0, 1, 1);
        idle(4); gate_i = 1'b0; idle(4);
        read_back(v, 1'b0);
        check("R5 count continues after wrap", v, exp_held(4101));

        // R6: gate toggling during readback has no effect
        measure(SRC_INPUT, 4000, 1'b1, 1'b1, v);
        check("R6 readback with gate toggling", v, 4000);

        // R7: clear after a value with carry set
        measure(SRC_INPUT, 2100, 1'b1, 1'b0, v);
        check("R7 preload value", v, 2100);
        // readback left the count at zero; load again without reading
        do_clear();
        mode_i = SRC_INPUT; idle(2);
        gate_i = 1'b1; idle(4);
        for (int i = 0; i < 2100; i++) pulse(0, 1, 1);
        idle(4); gate_i = 1'b0; idle(4);
        check("R7 carry before clear", int'(carry_o), 1);
        do_clear();
        check("R7 carry after clear", int'(carry_o), 0);
        read_back(v, 1'b0);
        check("R7 count after clear", v, 0);

        // R9: mode off counts nothing
        do_clear();
        mode_i = SRC_OFF; idle(2);
        gate_i = 1'b1; idle(4);
        for (int i = 0; i < 6; i++) begin
            pulse(0, 1, 1); pulse(1, 1, 1); pulse(2, 1, 1);
        end
        idle(4); gate_i = 1'b0; idle(4);
        check("R9 carry with mode off", int'(carry_o), 0);
        read_back(v, 1'b0);
        check("R9 count with mode off", v, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule